// File: doc/BRIEF.md
# Prescaled Compare-Match Timer

This block is a single timer channel. A programmable prescaler divides an incoming timer tick, and each divided tick advances a 24-bit up-counter. When an advance makes the counter equal a 24-bit compare value, a match event occurs. The control word selects what the event does: one-shot stops the timer, periodic restarts it from zero, and continuous lets it run on.

Software drives the block through a small word-addressed register interface. The four registers are a control word, the compare value, a read-only view of the counter, and a status word. The status word holds an interrupt flag and a wake-up flag, and writing 1 to a flag clears it. The interrupt flag drives an interrupt request when interrupts are enabled. The wake-up flag records a match that happened while the power-down input was high and wake-up was enabled. Writing the control word with its counter-reset bit set clears the counter and the prescaler.

Top module: `cmt_timer`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `wake` are low.
- R2: The counter advances once for every (P+1) cycles in which `tmr_tick` is high, where P is control bits 7:0, and only while the enable bit (control bit 30) is 1. Ticks that arrive while enable is 0 leave the counter unchanged.
- R3: A match is an advance whose result equals the compare value. A match sets status bit 0 in the same clock edge, but only if the interrupt-enable bit (control bit 29) is 1.
- R4: In mode 0 (control bits 28:27 = 0, one-shot), a match returns the counter to 0 and clears control bit 30.
- R5: In mode 1 (periodic), a match returns the counter to 0 and counting continues. Mode 2 behaves exactly like mode 1.
- R6: In mode 3 (continuous), a match does not reset the counter. The counter keeps counting and wraps from all ones to 0.
- R7: Writing 1 to status bit 0 or status bit 8 clears that flag, and writing 0 to a flag leaves it unchanged. If a hardware set and a write-1 clear happen in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when status bit 0 is 1 and control bit 29 is 1.
- R9: A match sets status bit 8 only when the wake-enable bit (control bit 23) is 1 and `pwr_down` is high. The `wake` output follows status bit 8.
- R10: A control write with bit 26 set clears the counter and the prescaler in that clock edge. Bit 26 always reads back as 0.
- R11: The register addresses are 0 for control, 1 for compare (only the low 24 bits are kept), 2 for the counter, and 3 for status. Writes to address 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_tick | input | 1 | Timer clock enable, one pulse per timer clock |
| pwr_down | input | 1 | High while the device is in power-down |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up indication |

## Verification
A register write, a prescaler advance, a match, a flag update and a counter reset all take effect at the same clock edge that samples the stimulus. Each result is therefore visible one cycle after it is applied. `reg_rdata` and `irq` are combinational views of that registered state. The bench applies every stimulus at a falling edge and reads the results at the next falling edge, one register stage later. For each expected counter value it counts ticks exactly, so it reads the value after the edge that produced it.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'd0,
        MODE_PERIOD  = 2'd1,
        MODE_RSVD    = 2'd2,
        MODE_CONT    = 2'd3
    } tmr_mode_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int BIT_EN    = 30;
    localparam int BIT_IE    = 29;
    localparam int BIT_MODE  = 27;
    localparam int BIT_CRST  = 26;
    localparam int BIT_WKEN  = 23;
    localparam int BIT_TIF   = 0;
    localparam int BIT_TWF   = 8;

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PSC_W-1:0] div,
    output logic             adv
);
    localparam logic [PSC_W-1:0] STEP = 1;

    logic [PSC_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        adv   = 1'b0;
        if (clr) begin
            pre_d = '0;
        end else if (run) begin
            if (pre_q == div) begin
                pre_d = '0;
                adv   = 1'b1;
            end else begin
                pre_d = pre_q + STEP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    localparam logic [CNT_W-1:0] STEP = 1;

    logic [CNT_W-1:0] cnt_d, cnt_q, inc;

    always_comb begin
        inc   = cnt_q + STEP;
        cnt_d = cnt_q;
        hit   = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (adv) begin
            cnt_d = inc;
            if (inc == cmp) begin
                hit = 1'b1;
                if (mode != MODE_CONT) cnt_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PSC_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tmr_tick,
    input  logic        pwr_down,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        wake
);
    typedef struct packed {
        logic             en;
        logic             ie;
        tmr_mode_e        mode;
        logic             wken;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] cmp;
        logic             tif;
        logic             twf;
    } regs_t;

    regs_t st_d, st_q;

    logic             wr_ctrl, wr_cmp, wr_stat;
    logic             clr, run, adv, hit;
    logic [CNT_W-1:0] cnt;

    logic             ctl_en, ctl_ie, ctl_wken, flag_tif, flag_twf;
    logic [1:0]       ctl_mode;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_cmp  = reg_wr && (reg_addr == ADDR_CMP);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
    assign clr     = wr_ctrl && reg_wdata[BIT_CRST];
    assign run     = st_q.en && tmr_tick;

    cmt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (clr),
        .div   (st_q.psc),
        .adv   (adv)
    );

    cmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .clr   (clr),
        .mode  (st_q.mode),
        .cmp   (st_q.cmp),
        .cnt   (cnt),
        .hit   (hit)
    );

    always_comb begin
        st_d = st_q;
        if (wr_stat) begin
            if (reg_wdata[BIT_TIF]) st_d.tif = 1'b0;
            if (reg_wdata[BIT_TWF]) st_d.twf = 1'b0;
        end
        if (wr_ctrl) begin
            st_d.en   = reg_wdata[BIT_EN];
            st_d.ie   = reg_wdata[BIT_IE];
            st_d.mode = tmr_mode_e'(reg_wdata[BIT_MODE+1:BIT_MODE]);
            st_d.wken = reg_wdata[BIT_WKEN];
            st_d.psc  = reg_wdata[PSC_W-1:0];
        end
        if (wr_cmp) st_d.cmp = reg_wdata[CNT_W-1:0];
        if (hit && st_q.ie) st_d.tif = 1'b1;
        if (hit && st_q.wken && pwr_down) st_d.twf = 1'b1;
        if (hit && (st_q.mode == MODE_ONESHOT)) st_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[BIT_EN]                = st_q.en;
                reg_rdata[BIT_IE]                = st_q.ie;
                reg_rdata[BIT_MODE+1:BIT_MODE]   = st_q.mode;
                reg_rdata[BIT_WKEN]              = st_q.wken;
                reg_rdata[PSC_W-1:0]             = st_q.psc;
            end
            ADDR_CMP:  reg_rdata[CNT_W-1:0] = st_q.cmp;
            ADDR_CNT:  reg_rdata[CNT_W-1:0] = cnt;
            ADDR_STAT: begin
                reg_rdata[BIT_TIF] = st_q.tif;
                reg_rdata[BIT_TWF] = st_q.twf;
            end
            default:   reg_rdata = '0;
        endcase
    end

    assign irq  = st_q.tif && st_q.ie;
    assign wake = st_q.twf;

    assign ctl_en   = st_q.en;
    assign ctl_ie   = st_q.ie;
    assign ctl_wken = st_q.wken;
    assign ctl_mode = st_q.mode;
    assign flag_tif = st_q.tif;
    assign flag_twf = st_q.twf;

endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit,
    input logic             clr,
    input logic             en,
    input logic             ie,
    input logic [1:0]       mode,
    input logic             wken,
    input logic             pwr_down,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             tif,
    input logic             irq,
    input logic             wake
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt));

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ie) |=> tif);

    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == 2'd0) |=> (!en && cnt == '0));

    // R5
    periodic_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (mode == 2'd1 || mode == 2'd2)) |=> (cnt == '0));

    // R6
    cont_runon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == 2'd3) |=> (cnt == $past(cmp)));

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq);

    // R9
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(hit && wken && pwr_down));

    // R10
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

bind cmt_timer cmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .clr      (clr),
    .en       (ctl_en),
    .ie       (ctl_ie),
    .mode     (ctl_mode),
    .wken     (ctl_wken),
    .pwr_down (pwr_down),
    .cnt      (cnt),
    .cmp      (st_q.cmp),
    .tif      (flag_tif),
    .irq      (irq),
    .wake     (wake)
);

// File: tb/cmt_timer_bench.sv
module cmt_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_tick = 1'b0;
    logic        pwr_down = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, n_rdata;
    logic        irq, wake, n_irq, n_wake;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    cmt_timer u_cmt_timer (
        .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .pwr_down(pwr_down),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .wake(wake)
    );

    cmt_timer #(.CNT_W(8)) u_cmt_timer_narrow (
        .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .pwr_down(pwr_down),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(n_rdata), .irq(n_irq), .wake(n_wake)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input logic en, input logic ie, input logic [1:0] md,
                                        input logic crst, input logic wk, input logic [7:0] psc);
        logic [31:0] w;
        w = '0;
        w[30] = en; w[29] = ie; w[28:27] = md; w[26] = crst; w[23] = wk; w[7:0] = psc;
        return w;
    endfunction

    task automatic step(input logic tk, input logic w, input logic [1:0] a, input logic [31:0] d);
        tmr_tick = tk; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        tmr_tick = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        step(1'b0, 1'b1, a, d);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, '0);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd_narrow(output logic [31:0] v);
        reg_addr = 2'd2;
        #1;
        v = n_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pwr_down = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 register after reset", v, 32'h0);
        end
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 wake after reset", {31'b0, wake}, 32'h0);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        do_reset();
        wr(2'd1, 32'd1000);
        wr(2'd0, ctl(1, 0, 2'd1, 0, 0, 8'd0));
        ticks(7);
        rd(2'd2, v); check("R2 divide by 1", v, 32'd7);
        step(1'b0, 1'b0, 2'd0, '0); step(1'b0, 1'b0, 2'd0, '0);
        rd(2'd2, v); check("R2 no tick no advance", v, 32'd7);
        do_reset();
        wr(2'd1, 32'd1000);
        wr(2'd0, ctl(1, 0, 2'd1, 0, 0, 8'd2));
        ticks(7);
        rd(2'd2, v); check("R2 divide by 3", v, 32'd2);
        do_reset();
        wr(2'd1, 32'd1000);
        wr(2'd0, ctl(0, 0, 2'd1, 0, 0, 8'd0));
        ticks(10);
        rd(2'd2, v); check("R2 disabled ignores ticks", v, 32'd0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        do_reset();
        wr(2'd1, 32'd5);
        wr(2'd0, ctl(1, 1, 2'd0, 0, 0, 8'd0));
        ticks(4);
        rd(2'd2, v); check("R4 count before match", v, 32'd4);
        rd(2'd3, v); check("R3 no flag before match", v, 32'd0);
        ticks(1);
        rd(2'd2, v); check("R4 counter zero at match", v, 32'd0);
        rd(2'd0, v); check("R4 enable cleared", v, ctl(0, 1, 2'd0, 0, 0, 8'd0));
        rd(2'd3, v); check("R3 flag set at match", v, 32'h1);
        check("R8 irq with flag and enable", {31'b0, irq}, 32'h1);
        ticks(3);
        rd(2'd2, v); check("R4 stopped after match", v, 32'd0);
    endtask

    task automatic t_noie();
        logic [31:0] v;
        do_reset();
        wr(2'd1, 32'd3);
        wr(2'd0, ctl(1, 0, 2'd1, 0, 0, 8'd0));
        ticks(3);
        rd(2'd2, v); check("R5 restart without ie", v, 32'd0);
        rd(2'd3, v); check("R3 no flag when ie=0", v, 32'd0);
        check("R8 irq low when ie=0", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        do_reset();
        wr(2'd1, 32'd4);
        wr(2'd0, ctl(1, 1, 2'd1, 0, 0, 8'd0));
        ticks(4);
        rd(2'd2, v); check("R5 counter zero at match", v, 32'd0);
        rd(2'd0, v); check("R5 enable stays set", v, ctl(1, 1, 2'd1, 0, 0, 8'd0));
        ticks(6);
        rd(2'd2, v); check("R5 keeps counting", v, 32'd2);
        do_reset();
        wr(2'd1, 32'd4);
        wr(2'd0, ctl(1, 0, 2'd2, 0, 0, 8'd0));
        ticks(5);
        rd(2'd2, v); check("R5 mode 2 as periodic", v, 32'd1);
    endtask

    task automatic t_cont();
        logic [31:0] v;
        do_reset();
        wr(2'd1, 32'd3);
        wr(2'd0, ctl(1, 1, 2'd3, 0, 0, 8'd0));
        ticks(5);
        rd(2'd2, v); check("R6 counts past match", v, 32'd5);
        rd(2'd3, v); check("R6 flag on match", v, 32'h1);
        do_reset();
        wr(2'd1, 32'd200);
        wr(2'd0, ctl(1, 0, 2'd3, 0, 0, 8'd0));
        ticks(255);
        rd_narrow(v); check("R6 narrow at all ones", v, 32'd255);
        ticks(1);
        rd_narrow(v); check("R6 narrow wraps to 0", v, 32'd0);
        rd(2'd2, v); check("R6 wide keeps counting", v, 32'd256);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        do_reset();
        wr(2'd1, 32'd3);
        wr(2'd0, ctl(1, 1, 2'd1, 0, 0, 8'd0));
        ticks(3);
        wr(2'd3, 32'h0);
        rd(2'd3, v); check("R7 write 0 keeps flag", v, 32'h1);
        ticks(2);
        step(1'b1, 1'b1, 2'd3, 32'h1);
        rd(2'd3, v); check("R7 set beats clear", v, 32'h1);
        wr(2'd0, ctl(1, 0, 2'd1, 0, 0, 8'd0));
        check("R8 irq masked by ie", {31'b0, irq}, 32'h0);
        rd(2'd3, v); check("R8 flag kept when masked", v, 32'h1);
        wr(2'd3, 32'h1);
        rd(2'd3, v); check("R7 write 1 clears", v, 32'h0);
    endtask

    task automatic t_wake();
        logic [31:0] v;
        do_reset();
        pwr_down = 1'b1;
        wr(2'd1, 32'd2);
        wr(2'd0, ctl(1, 0, 2'd1, 0, 1, 8'd0));
        ticks(2);
        rd(2'd3, v); check("R9 wake flag in power-down", v, 32'h100);
        check("R9 wake output", {31'b0, wake}, 32'h1);
        wr(2'd3, 32'h100);
        rd(2'd3, v); check("R7 wake flag cleared", v, 32'h0);
        pwr_down = 1'b0;
        ticks(2);
        rd(2'd3, v); check("R9 no wake when awake", v, 32'h0);
        check("R9 wake output low", {31'b0, wake}, 32'h0);
    endtask

    task automatic t_crst();
        logic [31:0] v;
        do_reset();
        wr(2'd1, 32'd1000);
        wr(2'd0, ctl(1, 0, 2'd1, 0, 0, 8'd3));
        ticks(6);
        rd(2'd2, v); check("R10 count before reset", v, 32'd1);
        wr(2'd0, ctl(1, 0, 2'd1, 1, 0, 8'd3));
        rd(2'd2, v); check("R10 counter cleared", v, 32'd0);
        rd(2'd0, v); check("R10 reset bit reads 0", v, ctl(1, 0, 2'd1, 0, 0, 8'd3));
        ticks(3);
        rd(2'd2, v); check("R10 prescaler cleared", v, 32'd0);
        ticks(1);
        rd(2'd2, v); check("R10 first advance after reset", v, 32'd1);
    endtask

    task automatic t_map();
        logic [31:0] v;
        do_reset();
        wr(2'd1, 32'hABCDEF12);
        rd(2'd1, v); check("R11 compare keeps 24 bits", v, 32'h00CDEF12);
        wr(2'd0, ctl(1, 1, 2'd3, 0, 1, 8'h5A));
        rd(2'd0, v); check("R11 control readback", v, ctl(1, 1, 2'd3, 0, 1, 8'h5A));
        wr(2'd0, ctl(1, 0, 2'd1, 0, 0, 8'd0));
        ticks(3);
        wr(2'd2, 32'h55);
        rd(2'd2, v); check("R11 counter write ignored", v, 32'd3);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_prescale();
        t_oneshot();
        t_noie();
        t_periodic();
        t_cont();
        t_w1c();
        t_wake();
        t_crst();
        t_map();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule